// File: doc/BRIEF.md
# Write-Completion Status Read-Back

This block sits in the read path of a memory whose writes run on an internal timer. While the busy flag is raised, it replaces the byte returned to the host with a status byte that the host can poll to learn when the write has finished. Once busy drops, the array data passes through unchanged.

Two polling methods are supported at the same time. In the first, the polling bit carries the inverse of that bit in the byte last written. It therefore reads back true only after the write completes. In the second, the toggling bit changes value on every read while the write is running and stops once it ends.

A read is marked by a strobe input; only its rising edge counts as a read. The busy flag may come from a real programming period or from a dummy period started by a blocked write. The block treats both the same way. Address decode and output tristate timing belong to the surrounding logic.

Top module: `wr_status_readback`

## Requirements
- R1: While busy_i is 0, rd_data_o equals array_rd_i on every bit.
- R2: While busy_i is 1, bit 7 of rd_data_o is the inverse of bit 7 of last_wr_i.
- R3: While busy_i is 1, bits 5 down to 0 of rd_data_o equal bits 5 down to 0 of last_wr_i.
- R4: While busy_i is 1, bit 6 of rd_data_o shows the toggle state. The toggle state inverts exactly once for each rising edge of rd_strobe_i seen at a clock edge while busy_i is 1. A strobe held high for several cycles counts once.
- R5: Rising edges of rd_strobe_i while busy_i is 0 leave the toggle state unchanged. This is seen on bit 6 at the next busy read.
- R6: After reset the toggle state is 0. With no strobe, the first busy read shows bit 6 at 0. The state is never cleared by busy falling, so a new write cycle starts from the level left by the previous one.
- R7: While busy_i is 1, changes on array_rd_i have no effect on rd_data_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Self-timed write (real or dummy) in progress |
| last_wr_i | input | 8 | Last byte loaded by the host |
| array_rd_i | input | 8 | Data read from the array |
| rd_strobe_i | input | 1 | Read access strobe; rising edge counts one read |
| rd_data_o | output | 8 | Read data returned to the host |

## Verification
The hardest case to reach is a strobe that stays high over several clocks while busy, and an edge that arrives while idle just before a new write cycle. In both cases the toggle must neither flip twice nor lose its level. Directed steps hold the strobe for three cycles, and they pulse it between write cycles before raising busy again. A seeded random phase then mixes busy runs, strobe lengths and data so that edges fall on every busy transition.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
   typedef enum logic {
      WSR_OUT_COMB = 1'b0,
      WSR_OUT_REG  = 1'b1
   } out_mode_e;
endpackage

// File: rtl/wsr_strobe_edge.sv
module wsr_strobe_edge (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic strobe_i,
   output logic rise_o
);
   logic strobe_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) strobe_q <= 1'b0;
      else         strobe_q <= strobe_i;
   end

   assign rise_o = strobe_i & ~strobe_q;

   // R4
   rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |=> !rise_o);
endmodule

// File: rtl/wsr_toggle_reg.sv
module wsr_toggle_reg #(
   parameter bit TOG_RESET = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic busy_i,
   input  logic rise_i,
   output logic tog_o
);
   logic tog_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              tog_q <= TOG_RESET;
      else if (busy_i && rise_i) tog_q <= ~tog_q;
   end

   assign tog_o = tog_q;

   // R4
   tog_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_i && rise_i) |=> (tog_o != $past(tog_o)));
   // R5
   tog_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(busy_i && rise_i) |=> $stable(tog_o));
endmodule

// File: rtl/wsr_status_mux.sv
module wsr_status_mux #(
   parameter int                 DATA_W   = 8,
   parameter int                 POLL_BIT = 7,
   parameter int                 TOG_BIT  = 6,
   parameter wsr_pkg::out_mode_e OUT_MODE = wsr_pkg::WSR_OUT_COMB
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              busy_i,
   input  logic              tog_i,
   input  logic [DATA_W-1:0] last_i,
   input  logic [DATA_W-1:0] array_i,
   output logic [DATA_W-1:0] data_o
);
   logic [DATA_W-1:0] status;
   logic [DATA_W-1:0] sel;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i == POLL_BIT) begin : g_poll
         assign status[i] = ~last_i[i];
      end else if (i == TOG_BIT) begin : g_tog
         assign status[i] = tog_i;
      end else begin : g_pass
         assign status[i] = last_i[i];
      end
   end

   assign sel = busy_i ? status : array_i;

   if (OUT_MODE == wsr_pkg::WSR_OUT_REG) begin : g_reg
      logic [DATA_W-1:0] data_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) data_q <= '0;
         else         data_q <= sel;
      end
      assign data_o = data_q;

      // R1
      idle_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !busy_i |=> (data_o == $past(array_i)));
      // R2
      poll_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         busy_i |=> (data_o[POLL_BIT] != $past(last_i[POLL_BIT])));
   end else begin : g_comb
      assign data_o = sel;

      // R1
      idle_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !busy_i |-> (data_o == array_i));
      // R2
      poll_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         busy_i |-> (data_o[POLL_BIT] != last_i[POLL_BIT]));
      // R4
      tog_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         busy_i |-> (data_o[TOG_BIT] == tog_i));
   end
endmodule

// File: rtl/wr_status_readback.sv
module wr_status_readback #(
   parameter int                 DATA_W    = 8,
   parameter int                 POLL_BIT  = 7,
   parameter int                 TOG_BIT   = 6,
   parameter bit                 TOG_RESET = 1'b0,
   parameter wsr_pkg::out_mode_e OUT_MODE  = wsr_pkg::WSR_OUT_COMB
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              busy_i,
   input  logic [DATA_W-1:0] last_wr_i,
   input  logic [DATA_W-1:0] array_rd_i,
   input  logic              rd_strobe_i,
   output logic [DATA_W-1:0] rd_data_o
);
   initial begin
      param_chk: assert (DATA_W >= 2 && POLL_BIT < DATA_W && TOG_BIT < DATA_W
                         && POLL_BIT != TOG_BIT)
         else $error("wr_status_readback: bad bit positions");
   end

   logic rise;
   logic tog;

   wsr_strobe_edge i_edge (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .strobe_i (rd_strobe_i),
      .rise_o   (rise)
   );

   wsr_toggle_reg #(.TOG_RESET(TOG_RESET)) i_tog (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .busy_i (busy_i),
      .rise_i (rise),
      .tog_o  (tog)
   );

   wsr_status_mux #(
      .DATA_W   (DATA_W),
      .POLL_BIT (POLL_BIT),
      .TOG_BIT  (TOG_BIT),
      .OUT_MODE (OUT_MODE)
   ) i_mux (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .busy_i  (busy_i),
      .tog_i   (tog),
      .last_i  (last_wr_i),
      .array_i (array_rd_i),
      .data_o  (rd_data_o)
   );
endmodule

// File: tb/test_wr_status_readback.sv
module test_wr_status_readback;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       busy = 1'b0;
   logic [7:0] last = '0;
   logic [7:0] arr = '0;
   logic       strobe = 1'b0;
   logic [7:0] rd;

   int total = 0;
   int bad = 0;
   bit m_tog = 1'b0;
   bit m_prev = 1'b0;

   always #10 clk = ~clk;

   wr_status_readback i_wr_status_readback (
      .clk_i (clk), .rst_ni (rst_n), .busy_i (busy), .last_wr_i (last),
      .array_rd_i (arr), .rd_strobe_i (strobe), .rd_data_o (rd)
   );

   function automatic logic [7:0] exp_out(bit b, logic [7:0] l, logic [7:0] a, bit t);
      logic [7:0] r;
      if (!b) return a;
      r    = l;
      r[7] = ~l[7];
      r[6] = t;
      return r;
   endfunction

   task automatic check(string req, logic [7:0] exp);
      total++;
      if (rd !== exp) begin
         bad++;
         $display("FAIL %s: rd_data=%h expected=%h", req, rd, exp);
      end
   endtask

   task automatic step(bit b, bit s, logic [7:0] l, logic [7:0] a, string req);
      @(negedge clk);
      busy = b; strobe = s; last = l; arr = a;
      @(posedge clk);
      if (s && !m_prev && b) m_tog = ~m_tog;
      m_prev = s;
      #5;
      check(req, exp_out(b, l, a, m_tog));
   endtask

   initial begin
      #4_000_000;
      bad++; total++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      arr = 8'h3C;
      repeat (3) @(negedge clk);
      #1 check("R1 reset idle", 8'h3C);
      rst_n = 1'b1;
      // R6: no strobe yet, toggle starts at 0
      step(1, 0, 8'h95, 8'hFF, "R6 first busy read");
      check("R2 R3 poll bits", 8'h15);
      // R4: single pulse flips
      step(1, 1, 8'h95, 8'hFF, "R4 pulse flip");
      check("R4 bit6 high", 8'h55);
      step(1, 0, 8'h95, 8'hFF, "R4 after pulse");
      // R4: held strobe counts once
      step(1, 1, 8'h2A, 8'h00, "R4 held 1");
      step(1, 1, 8'h2A, 8'h00, "R4 held 2");
      step(1, 1, 8'h2A, 8'h00, "R4 held 3");
      check("R4 held once", 8'hAA);
      step(1, 0, 8'h2A, 8'h00, "R4 release");
      // R5: idle strobes ignored, R6 level kept across cycles
      step(0, 1, 8'h2A, 8'h81, "R5 idle strobe");
      step(0, 0, 8'h2A, 8'h81, "R1 idle");
      step(0, 1, 8'h2A, 8'h81, "R5 idle strobe 2");
      step(1, 1, 8'h00, 8'h81, "R5 busy with held strobe");
      check("R5 level kept", 8'h80);
      // R7: array changes ignored while busy
      step(1, 0, 8'h7F, 8'h00, "R7 arr 00");
      step(1, 0, 8'h7F, 8'hFF, "R7 arr FF");
      check("R7 unchanged", 8'hBF);
      for (int k = 0; k < 400; k++) begin
         bit b = ($urandom % 4) != 0;
         bit s = ($urandom % 3) == 0;
         step(b, s, 8'($urandom), 8'($urandom),
              b ? "R2 R3 R4 R7 random" : "R1 R5 random");
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule